// File: doc/BRIEF.md
# Framed Serial Readout Master for a 12-bit Converter

This block reads conversion results out of an analog-to-digital converter through its framed serial port. On a start request it pulls an active-low frame strobe down and, after a set-up interval, toggles a serial clock from a divided system clock. On every falling edge of that clock it captures one bit of the data line, most significant bit first. After the last bit it keeps the frame strobe low for a hold interval, then releases the strobe and the clock together and presents the assembled word with a single-cycle valid pulse.

All intervals are whole numbers of system-clock cycles, derived at elaboration from the system-clock period and the converter's limits in nanoseconds. The clock half-period requested by the integrator is raised when it is shorter than the minimum width, or shorter than the converter's data launch delay after a rising edge. Because of that raise, every sample lands after the data line has settled. Requests that arrive while a frame is running are dropped.

Top module: `adc_serial_reader`

## Requirements
- R1: While and after reset, with no start request, `fs_n_o` and `sclk_o` are 1, `valid_o` is 0 and `word_o` is 0.
- R2: A start request seen in idle drives `fs_n_o` low in the next cycle with `sclk_o` still high. The first `sclk_o` fall comes exactly LEAD cycles after `fs_n_o` falls, where LEAD = max(HALF, ceil(max(SETUP_NS, LAUNCH_NS) / CLK_NS)).
- R3: HALF = max(HALF_CYC, 1, ceil(max(MIN_WIDTH_NS, LAUNCH_NS) / CLK_NS)). Every low phase and every high phase of `sclk_o` that lies between two clock edges inside a frame lasts exactly HALF cycles. A HALF_CYC below the minimum is raised to it.
- R4: A frame contains exactly WORD_W falling edges of `sclk_o`, and `sclk_o` is high whenever `fs_n_o` is high.
- R5: `sdata_i` is captured in the cycle in which `sclk_o` goes low. The bit taken at the first fall ends up in `word_o[WORD_W-1]` and the bit taken at the last fall in `word_o[0]`.
- R6: After the last fall, `fs_n_o` and `sclk_o` both stay low for TAIL cycles, where TAIL = max(HALF, ceil(HOLD_NS / CLK_NS)). Both then rise in the same cycle.
- R7: `valid_o` is high for exactly one cycle, the cycle in which `fs_n_o` returns high. `word_o` takes the new result in that cycle and holds its value in every other cycle.
- R8: A start request during a frame has no effect. A start request that is high when the block is idle, including the cycle right after a release, begins a new frame in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one readout |
| sdata_i | input | 1 | Serial data line from the converter |
| fs_n_o | output | 1 | Active-low frame strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| word_o | output | WORD_W | Last assembled result |
| valid_o | output | 1 | One-cycle pulse when `word_o` is new |

## Verification
Every cycle, the checker confirms several properties:
- the clock idles high outside a frame;
- each inner clock phase lasts exactly the derived half-period;
- a frame holds the full count of falling edges;
- the strobe and the clock are released together with the valid pulse;
- the result stays still between pulses.

Some behaviour only the bench scenarios can show:
- the bit order and value of the captured word over walking-bit and arithmetic patterns;
- the exact set-up and hold intervals measured from the strobe;
- that requests during a frame are dropped;
- that a request held across a release starts the next frame at once.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } rd_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Half-period in system cycles: the request, raised to the width limit
  // and to the data launch delay so the sample point sees settled data.
  function automatic int half_cycles(input int clk_ns, input int req,
                                     input int width_ns, input int launch_ns);
    return max2(max2(req, 1), ceil_div(max2(width_ns, launch_ns), clk_ns));
  endfunction

  function automatic int lead_cycles(input int clk_ns, input int half,
                                     input int setup_ns, input int launch_ns);
    return max2(half, ceil_div(max2(setup_ns, launch_ns), clk_ns));
  endfunction

  function automatic int tail_cycles(input int clk_ns, input int half,
                                     input int hold_ns);
    return max2(half, ceil_div(hold_ns, clk_ns));
  endfunction

endpackage

// File: rtl/adc_rd_timer.sv
`timescale 1ns/1ps
module adc_rd_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/adc_rd_shift.sv
`timescale 1ns/1ps
module adc_rd_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         bit_i,
  output logic [W-1:0] word,
  output logic         last
);

  localparam int BW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [BW-1:0] n_q;

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else if (en) sh_q <= bit_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else if (en) sh_q <= {sh_q[W-2:0], bit_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      n_q <= '0;
    end else if (en) begin
      n_q <= n_q + 1'b1;
    end
  end

  assign word = sh_q;
  assign last = (n_q == BW'(W - 1));

endmodule

// File: rtl/adc_rd_seq.sv
`timescale 1ns/1ps
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int CW   = 4,
  parameter int LEAD = 4,
  parameter int HALF = 3,
  parameter int TAIL = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          t_zero,
  input  logic          last,
  output logic          t_load,
  output logic [CW-1:0] t_val,
  output logic          sh_clr,
  output logic          sh_en,
  output logic          cap,
  output logic          fs_n_o,
  output logic          sclk_o,
  output logic          valid_o
);

  localparam logic [CW-1:0] LEAD_V = CW'(LEAD - 1);
  localparam logic [CW-1:0] HALF_V = CW'(HALF - 1);
  localparam logic [CW-1:0] TAIL_V = CW'(TAIL - 1);

  rd_state_t st_q, st_d;

  always_comb begin
    st_d   = st_q;
    t_load = 1'b0;
    t_val  = '0;
    sh_clr = 1'b0;
    sh_en  = 1'b0;
    cap    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_LEAD;
          t_load = 1'b1;
          t_val  = LEAD_V;
          sh_clr = 1'b1;
        end
      end
      ST_LEAD, ST_HIGH: begin
        if (t_zero) begin
          sh_en  = 1'b1;
          t_load = 1'b1;
          if (last) begin
            st_d  = ST_TAIL;
            t_val = TAIL_V;
          end else begin
            st_d  = ST_LOW;
            t_val = HALF_V;
          end
        end
      end
      ST_LOW: begin
        if (t_zero) begin
          st_d   = ST_HIGH;
          t_load = 1'b1;
          t_val  = HALF_V;
        end
      end
      ST_TAIL: begin
        if (t_zero) begin
          st_d = ST_IDLE;
          cap  = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      fs_n_o  <= 1'b1;
      sclk_o  <= 1'b1;
      valid_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      fs_n_o  <= (st_d == ST_IDLE);
      sclk_o  <= (st_d == ST_IDLE) || (st_d == ST_LEAD) || (st_d == ST_HIGH);
      valid_o <= cap;
    end
  end

endmodule

// File: rtl/adc_serial_reader.sv
`timescale 1ns/1ps
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int CLK_NS       = 10,
  parameter int HALF_CYC     = 4,
  parameter int WORD_W       = 12,
  parameter int MIN_WIDTH_NS = 25,
  parameter int LAUNCH_NS    = 30,
  parameter int SETUP_NS     = 35,
  parameter int HOLD_NS      = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              sdata_i,
  output logic              fs_n_o,
  output logic              sclk_o,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);

  localparam int HALF_E = half_cycles(CLK_NS, HALF_CYC, MIN_WIDTH_NS, LAUNCH_NS);
  localparam int LEAD_E = lead_cycles(CLK_NS, HALF_E, SETUP_NS, LAUNCH_NS);
  localparam int TAIL_E = tail_cycles(CLK_NS, HALF_E, HOLD_NS);
  localparam int CNT_W  = $clog2(max2(LEAD_E, max2(HALF_E, TAIL_E))) + 1;

  logic              t_load, t_zero;
  logic [CNT_W-1:0]  t_val;
  logic              sh_clr, sh_en, sh_last, cap;
  logic [WORD_W-1:0] sh_word;

  adc_rd_timer #(.CW(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  adc_rd_shift #(.W(WORD_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .clr   (sh_clr),
    .en    (sh_en),
    .bit_i (sdata_i),
    .word  (sh_word),
    .last  (sh_last)
  );

  adc_rd_seq #(
    .CW   (CNT_W),
    .LEAD (LEAD_E),
    .HALF (HALF_E),
    .TAIL (TAIL_E)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .t_zero  (t_zero),
    .last    (sh_last),
    .t_load  (t_load),
    .t_val   (t_val),
    .sh_clr  (sh_clr),
    .sh_en   (sh_en),
    .cap     (cap),
    .fs_n_o  (fs_n_o),
    .sclk_o  (sclk_o),
    .valid_o (valid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) word_o <= '0;
    else if (cap) word_o <= sh_word;
  end

endmodule

// File: rtl/adc_serial_reader_chk.sv
`timescale 1ns/1ps
module adc_serial_reader_chk
  import adc_rd_pkg::*;
#(
  parameter int CLK_NS       = 10,
  parameter int HALF_CYC     = 4,
  parameter int WORD_W       = 12,
  parameter int MIN_WIDTH_NS = 25,
  parameter int LAUNCH_NS    = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              fs_n_o,
  input logic              sclk_o,
  input logic [WORD_W-1:0] word_o,
  input logic              valid_o
);

  localparam int HALF_E = half_cycles(CLK_NS, HALF_CYC, MIN_WIDTH_NS, LAUNCH_NS);

  logic prev_s;
  logic hi_in;
  int   run;
  int   falls;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_s <= 1'b1;
      hi_in  <= 1'b0;
      run    <= 0;
      falls  <= 0;
    end else begin
      prev_s <= sclk_o;
      run    <= (sclk_o != prev_s) ? 1 : run + 1;
      if (sclk_o && !prev_s) hi_in <= !fs_n_o;
      else if (!sclk_o || fs_n_o) hi_in <= 1'b0;
      if (fs_n_o) falls <= 0;
      else if (!sclk_o && prev_s) falls <= falls + 1;
    end
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (fs_n_o && sclk_o && !valid_o));

  // R2
  a_r2_frame_needs_start: assert property (@(posedge clk) disable iff (rst)
    $fell(fs_n_o) |-> ($past(start_i) && sclk_o));

  // R3
  a_r3_low_phase: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && !prev_s && !fs_n_o) |-> (run == HALF_E));

  // R3
  a_r3_high_phase: assert property (@(posedge clk) disable iff (rst)
    (!sclk_o && prev_s && hi_in) |-> (run == HALF_E));

  // R4
  a_r4_idle_clock_high: assert property (@(posedge clk) disable iff (rst)
    fs_n_o |-> sclk_o);

  // R4
  a_r4_fall_count: assert property (@(posedge clk) disable iff (rst)
    $rose(fs_n_o) |-> (falls == WORD_W));

  // R6
  a_r6_release_together: assert property (@(posedge clk) disable iff (rst)
    $rose(fs_n_o) |-> $rose(sclk_o));

  // R7
  a_r7_valid_at_release: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $rose(fs_n_o));

  // R7
  a_r7_release_gives_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(fs_n_o) |-> valid_o);

  // R7
  a_r7_word_holds: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(word_o));

endmodule

bind adc_serial_reader adc_serial_reader_chk #(
  .CLK_NS       (CLK_NS),
  .HALF_CYC     (HALF_CYC),
  .WORD_W       (WORD_W),
  .MIN_WIDTH_NS (MIN_WIDTH_NS),
  .LAUNCH_NS    (LAUNCH_NS)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .fs_n_o  (fs_n_o),
  .sclk_o  (sclk_o),
  .word_o  (word_o),
  .valid_o (valid_o)
);

// File: tb/test_adc_serial_reader.sv
`timescale 1ns/1ps
module test_adc_serial_reader;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 12;
  localparam int REQ_HALF   = 1;
  localparam int HOLD_NS    = 50;
  // Expected intervals computed from the requirement formulas.
  localparam int H_EXP    = ((30 + CLK_PERIOD - 1) / CLK_PERIOD > REQ_HALF) ?
                            (30 + CLK_PERIOD - 1) / CLK_PERIOD : REQ_HALF;
  localparam int LEAD_EXP = ((35 + CLK_PERIOD - 1) / CLK_PERIOD > H_EXP) ?
                            (35 + CLK_PERIOD - 1) / CLK_PERIOD : H_EXP;
  localparam int TAIL_EXP = ((HOLD_NS + CLK_PERIOD - 1) / CLK_PERIOD > H_EXP) ?
                            (HOLD_NS + CLK_PERIOD - 1) / CLK_PERIOD : H_EXP;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         sdata_i = 1'b0;
  logic         fs_n_o, sclk_o, valid_o;
  logic [W-1:0] word_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_serial_reader #(
    .CLK_NS   (CLK_PERIOD),
    .HALF_CYC (REQ_HALF),
    .WORD_W   (W),
    .HOLD_NS  (HOLD_NS)
  ) i_adc_serial_reader (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .sdata_i (sdata_i),
    .fs_n_o  (fs_n_o),
    .sclk_o  (sclk_o),
    .word_o  (word_o),
    .valid_o (valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One readout with a converter model that launches bits on sclk rises.
  task automatic frame(input logic [W-1:0] pat, input bit chained,
                       input bit keep, input int mid_t);
    int   t = 0;
    int   idx = W - 1;
    int   falls = 0;
    int   t_first = -1;
    int   t_last = -1;
    int   t_chg = 0;
    int   badrun = 0;
    logic ps = 1'b1;
    bit   done = 1'b0;
    if (!chained) begin
      start_i = 1'b1;
      @(negedge clk);
      if (!keep) start_i = 1'b0;
    end
    chk(fs_n_o == 1'b0 && sclk_o == 1'b1, "R2 strobe low with clock high after start",
        int'(fs_n_o), 0);
    sdata_i = pat[idx];
    while (!done) begin
      @(negedge clk);
      t++;
      if (t == mid_t) start_i = 1'b1;
      else if (mid_t > 0 && t == mid_t + 1) start_i = keep;
      if (sclk_o != ps) begin
        if (!sclk_o) begin
          falls++;
          if (t_first < 0) t_first = t;
          else if (t - t_chg != H_EXP) badrun++;
          t_last = t;
        end else if (!fs_n_o) begin
          if (t - t_chg != H_EXP) badrun++;
          idx--;
          if (idx >= 0) sdata_i = pat[idx];
        end
        t_chg = t;
        ps = sclk_o;
      end
      if (fs_n_o) done = 1'b1;
      else if (t > 2000) begin
        chk(1'b0, "R6 strobe never released", t, 0);
        done = 1'b1;
      end
    end
    chk(t_first == LEAD_EXP, "R2 set-up cycles before first fall", t_first, LEAD_EXP);
    chk(badrun == 0, "R3 inner phases of derived half-period", badrun, 0);
    chk(falls == W, "R4 falling edges per frame", falls, W);
    chk(t - t_last == TAIL_EXP, "R6 hold cycles after last fall", t - t_last, TAIL_EXP);
    chk(sclk_o == 1'b1, "R6 clock rises with strobe", int'(sclk_o), 1);
    chk(valid_o == 1'b1, "R7 valid at release", int'(valid_o), 1);
    chk(word_o == pat, "R5 captured word MSB first", int'(word_o), int'(pat));
    @(negedge clk);
    if (keep) begin
      chk(fs_n_o == 1'b0, "R8 held start begins next frame at once", int'(fs_n_o), 0);
    end else begin
      chk(fs_n_o == 1'b1, "R8 no restart from request during frame", int'(fs_n_o), 1);
    end
    chk(valid_o == 1'b0, "R7 valid lasts one cycle", int'(valid_o), 0);
  endtask

  task automatic idle_check(input int n);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (!fs_n_o || !sclk_o || valid_o) bad++;
    end
    chk(bad == 0, "R8 idle stays quiet without start", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(fs_n_o && sclk_o && !valid_o && word_o == '0, "R1 state during reset",
        int'({fs_n_o, sclk_o, valid_o}), 6);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(fs_n_o && sclk_o && !valid_o && word_o == '0, "R1 state after reset",
        int'({fs_n_o, sclk_o, valid_o}), 6);

    for (int i = 0; i < W; i++) frame(W'(1 << i), 1'b0, 1'b0, 0);
    for (int i = 0; i < W; i++) frame(~W'(1 << i), 1'b0, 1'b0, 0);
    frame('0, 1'b0, 1'b0, 0);
    frame('1, 1'b0, 1'b0, 0);
    for (int i = 0; i < 40; i++) begin
      frame(W'((i * 1237 + i * i * 91) ^ (i << 7)), 1'b0, 1'b0,
            (i % 4 == 0) ? 10 + i : 0);
    end
    idle_check(12);

    frame(12'hA5C, 1'b0, 1'b1, 0);
    start_i = 1'b0;
    frame(12'h3E1, 1'b1, 1'b0, 0);
    idle_check(12);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule